// File: doc/BRIEF.md
# Programmable AND-OR Product-Term Array

This block is the logic core of a small programmable logic device. It takes twelve dedicated inputs and ten feedback signals and builds the true and the complement of each one, which gives 44 array lines. Each product term is a wide AND over the lines selected by that term's row in a configuration store. The block drives 132 terms. 120 of them are gathered into ten OR sums of unequal width. Ten more act as per-output enable terms. The last two are global preset and clear terms, which macrocells outside this block consume.

The path from inputs and configuration to every term and sum output is purely combinational. The configuration is held in registers. One control clears all crossings to open in a single clock edge. A word-write port replaces the 44-bit connection mask of one term. Software drives these ports to load a pattern: it erases first, then writes one row at a time.

Top module: `pla_core`

## Requirements
- R1: Array line 2s carries signal s and line 2s+1 carries its complement. Signals 0..11 are `ded_in[0..11]` and signals 12..21 are `fb_in[0..9]`. Bit b of a term's mask connects line b.
- R2: Each of the 132 terms is the AND of exactly the lines whose mask bit is 1, and it is visible on `pterm_out[t]`.
- R3: A term whose mask is all zero (every crossing open) is 1 for any input.
- R4: A term connected to both polarities of the same signal is 0 for any input.
- R5: Sum terms are packed contiguously from index 0. Output k uses 8, 10, 12, 14, 16, 16, 14, 12, 10, 8 terms for k = 0..9, so output 4 ends at term 59 and output 5 starts at term 60.
- R6: `sum_out[k]` is the OR of the terms assigned to output k.
- R7: `oe_term[k]` is term 120+k, `preset_term` is term 130 and `clear_term` is term 131.
- R8: With `wr_en` high, `erase` low and `wr_idx` < 132, the row `wr_idx` takes the value of `wr_mask` at the rising edge. The outputs reflect the new row from then on, and not before.
- R9: `erase` opens every crossing at the next rising edge. A write presented in the same cycle is ignored.
- R10: A write with `wr_idx` ≥ 132 changes no row.
- R11: While `rst_n` is low, and after it is released, every crossing is open, so all 132 terms read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low reset, opens all crossings |
| ded_in | input | 12 | Dedicated input signals |
| fb_in | input | 10 | Feedback / IO signals |
| erase | input | 1 | Bulk erase request |
| wr_en | input | 1 | Row write enable |
| wr_idx | input | 8 | Term index to write |
| wr_mask | input | 44 | Connection mask for the row |
| pterm_out | output | 132 | Every product term |
| sum_out | output | 10 | OR sums, one per output |
| oe_term | output | 10 | Output-enable terms |
| preset_term | output | 1 | Global synchronous preset term |
| clear_term | output | 1 | Global asynchronous clear term |

## Verification
The bench builds the block with its default parameters: 12 dedicated inputs, 10 feedback signals and a smallest OR width of 8. With these values the full 132-term layout is exercised, including the boundary between the two widest sums at terms 59/60 and the index range just past the last row. Random sparse masks give terms that switch with the inputs. Directed patterns cover the fully open term, the contradictory term and erase colliding with a write.

// File: rtl/pla_pkg.sv
package pla_pkg;

    // Width of the OR feeding output k: grows by two toward the middle, mirrored.
    function automatic int or_size(input int k, input int n_out, input int min_terms);
        int j;
        j = (k < n_out / 2) ? k : (n_out - 1 - k);
        return min_terms + 2 * j;
    endfunction

    // First term index of output k when sums are packed back to back.
    function automatic int or_base(input int k, input int n_out, input int min_terms);
        int acc;
        acc = 0;
        for (int i = 0; i < k; i++) acc += or_size(i, n_out, min_terms);
        return acc;
    endfunction

endpackage

// File: rtl/pla_cfg_mem.sv
module pla_cfg_mem #(
    parameter int TERMS = 132,
    parameter int LINES = 44,
    parameter int IDX_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          erase,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [LINES-1:0]              wr_mask,
    output logic [TERMS-1:0][LINES-1:0]   cfg_q
);

    typedef struct packed {
        logic [TERMS-1:0][LINES-1:0] cfg;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (erase) begin
            st_d.cfg = '0;
        end else if (wr_en && (int'(wr_idx) < TERMS)) begin
            st_d.cfg[wr_idx] = wr_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_q = st_q.cfg;

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
    parameter int N_SIG = 22,
    parameter int TERMS = 132,
    localparam int LINES = 2 * N_SIG
) (
    input  logic [N_SIG-1:0]              sig,
    input  logic [TERMS-1:0][LINES-1:0]   cfg,
    output logic [TERMS-1:0]              term
);

    logic [LINES-1:0] lines;

    for (genvar s = 0; s < N_SIG; s++) begin : g_line
        assign lines[2*s]   = sig[s];
        assign lines[2*s+1] = ~sig[s];
    end

    // An open crossing forces its AND input high; a connected one passes the line.
    for (genvar t = 0; t < TERMS; t++) begin : g_term
        assign term[t] = &(~cfg[t] | lines);
    end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int N_OUT     = 10,
    parameter int MIN_TERMS = 8,
    parameter int N_SUM     = 120
) (
    input  logic [N_SUM-1:0] sum_terms,
    output logic [N_OUT-1:0] sums
);

    for (genvar k = 0; k < N_OUT; k++) begin : g_or
        localparam int BASE = pla_pkg::or_base(k, N_OUT, MIN_TERMS);
        localparam int SIZE = pla_pkg::or_size(k, N_OUT, MIN_TERMS);
        assign sums[k] = |sum_terms[BASE +: SIZE];
    end

endmodule

// File: rtl/pla_core.sv
module pla_core #(
    parameter int N_DED     = 12,
    parameter int N_IO      = 10,
    parameter int MIN_TERMS = 8,
    localparam int N_SIG = N_DED + N_IO,
    localparam int LINES = 2 * N_SIG,
    localparam int N_SUM = pla_pkg::or_base(N_IO, N_IO, MIN_TERMS),
    localparam int TERMS = N_SUM + N_IO + 2,
    localparam int IDX_W = $clog2(TERMS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_DED-1:0]  ded_in,
    input  logic [N_IO-1:0]   fb_in,
    input  logic              erase,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINES-1:0]  wr_mask,
    output logic [TERMS-1:0]  pterm_out,
    output logic [N_IO-1:0]   sum_out,
    output logic [N_IO-1:0]   oe_term,
    output logic              preset_term,
    output logic              clear_term
);

    logic [TERMS-1:0][LINES-1:0] cfg_q;
    logic [N_SIG-1:0]            sig;

    assign sig = {fb_in, ded_in};

    pla_cfg_mem #(.TERMS(TERMS), .LINES(LINES), .IDX_W(IDX_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .erase   (erase),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_mask (wr_mask),
        .cfg_q   (cfg_q)
    );

    pla_and_plane #(.N_SIG(N_SIG), .TERMS(TERMS)) u_and (
        .sig  (sig),
        .cfg  (cfg_q),
        .term (pterm_out)
    );

    pla_or_plane #(.N_OUT(N_IO), .MIN_TERMS(MIN_TERMS), .N_SUM(N_SUM)) u_or (
        .sum_terms (pterm_out[N_SUM-1:0]),
        .sums      (sum_out)
    );

    assign oe_term     = pterm_out[N_SUM +: N_IO];
    assign preset_term = pterm_out[TERMS-2];
    assign clear_term  = pterm_out[TERMS-1];

endmodule

// File: rtl/pla_core_chk.sv
module pla_core_chk #(
    parameter int TERMS = 132,
    parameter int LINES = 44,
    parameter int IDX_W = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         erase,
    input logic                         wr_en,
    input logic [IDX_W-1:0]             wr_idx,
    input logic [LINES-1:0]             wr_mask,
    input logic [TERMS-1:0]             pterm_out,
    input logic [TERMS-1:0][LINES-1:0]  cfg
);

    // R9
    erase_opens_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> &pterm_out);

    // R9
    erase_beats_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase && wr_en) |=> (cfg == '0));

    // R8
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !erase && (int'(wr_idx) < TERMS)) |=> (cfg[$past(wr_idx)] == $past(wr_mask)));

    // R10
    bad_index_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !erase && (int'(wr_idx) >= TERMS)) |=> $stable(cfg));

    // R8
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !erase) |=> $stable(cfg));

endmodule

bind pla_core pla_core_chk #(.TERMS(TERMS), .LINES(LINES), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .erase     (erase),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_mask   (wr_mask),
    .pterm_out (pterm_out),
    .cfg       (cfg_q)
);

// File: tb/pla_core_test.sv
module pla_core_test;

    localparam int ND = 12, NI = 10, NL = 44, NT = 132, NSUM = 120;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic           rst_n = 1'b0;
    logic [ND-1:0]  ded_in = '0;
    logic [NI-1:0]  fb_in = '0;
    logic           erase = 1'b0, wr_en = 1'b0;
    logic [7:0]     wr_idx = '0;
    logic [NL-1:0]  wr_mask = '0;
    logic [NT-1:0]  pterm_out;
    logic [NI-1:0]  sum_out, oe_term;
    logic           preset_term, clear_term;

    pla_core uut (
        .clk(clk), .rst_n(rst_n), .ded_in(ded_in), .fb_in(fb_in),
        .erase(erase), .wr_en(wr_en), .wr_idx(wr_idx), .wr_mask(wr_mask),
        .pterm_out(pterm_out), .sum_out(sum_out), .oe_term(oe_term),
        .preset_term(preset_term), .clear_term(clear_term)
    );

    logic [NL-1:0] mdl [NT];
    int errs = 0, checks = 0;
    int sz [NI] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};

    function automatic logic [NL-1:0] lines_of(logic [ND-1:0] d, logic [NI-1:0] f);
        logic [NL-1:0] l;
        for (int s = 0; s < ND; s++) begin l[2*s] = d[s]; l[2*s+1] = ~d[s]; end
        for (int s = 0; s < NI; s++) begin l[2*(ND+s)] = f[s]; l[2*(ND+s)+1] = ~f[s]; end
        return l;
    endfunction

    function automatic logic [NT-1:0] exp_terms(logic [NL-1:0] l);
        logic [NT-1:0] v;
        for (int t = 0; t < NT; t++) v[t] = ((mdl[t] & l) == mdl[t]);
        return v;
    endfunction

    function automatic logic [NI-1:0] exp_sums(logic [NT-1:0] v);
        logic [NI-1:0] s;
        int base;
        base = 0;
        for (int k = 0; k < NI; k++) begin
            s[k] = 1'b0;
            for (int j = 0; j < sz[k]; j++) s[k] = s[k] | v[base + j];
            base += sz[k];
        end
        return s;
    endfunction

    task automatic check(string req, logic [NT-1:0] act, logic [NT-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all();
        logic [NT-1:0] tv;
        tv = exp_terms(lines_of(ded_in, fb_in));
        check("R2 terms", pterm_out, tv);
        check("R6 sums", NT'(sum_out), NT'(exp_sums(tv)));
        check("R7 control", NT'({oe_term, preset_term, clear_term}),
              NT'({tv[NSUM +: NI], tv[130], tv[131]}));
    endtask

    // Drive one cycle; compare outputs before the edge, update the model after it.
    task automatic step(logic er, logic we, logic [7:0] idx, logic [NL-1:0] m,
                        logic [ND-1:0] d, logic [NI-1:0] f);
        @(negedge clk);
        erase = er; wr_en = we; wr_idx = idx; wr_mask = m; ded_in = d; fb_in = f;
        #2 check_all();
        @(posedge clk);
        #1;
        if (er) begin
            for (int t = 0; t < NT; t++) mdl[t] = '0;
        end else if (we && idx < 8'(NT)) begin
            mdl[idx] = m;
        end
    endtask

    task automatic idle(logic [ND-1:0] d, logic [NI-1:0] f);
        step(1'b0, 1'b0, 8'd0, '0, d, f);
    endtask

    initial begin
        #2_000_000;
        errs++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int t = 0; t < NT; t++) mdl[t] = '0;

        // R11 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 in reset", pterm_out, {NT{1'b1}});
        rst_n = 1'b1;
        #2 check("R11 after release", pterm_out, {NT{1'b1}});

        // R3 open term true for any input
        idle(12'hA5C, 10'h2F3);
        check("R3 open", NT'(pterm_out[7]), NT'(1'b1));

        // R1 line mapping: preset connected to complement of fb_in[0] (line 25)
        step(1'b0, 1'b1, 8'd130, 44'h1 << 25, 12'h000, 10'h000);
        check("R1 fb0 comp low", NT'(preset_term), NT'(1'b1));
        idle(12'h000, 10'h001);
        check("R1 fb0 comp high", NT'(preset_term), NT'(1'b0));
        // clear connected to true of ded_in[5] (line 10)
        step(1'b0, 1'b1, 8'd131, 44'h1 << 10, 12'h020, 10'h000);
        check("R1 ded5 true", NT'(clear_term), NT'(1'b1));
        idle(12'hFDF, 10'h3FF);
        check("R1 ded5 low", NT'(clear_term), NT'(1'b0));

        // R4 both polarities of ded_in[0]
        step(1'b0, 1'b1, 8'd3, 44'h3, 12'h000, 10'h000);
        check("R4 contradiction d0=0", NT'(pterm_out[3]), NT'(1'b0));
        idle(12'h001, 10'h155);
        check("R4 contradiction d0=1", NT'(pterm_out[3]), NT'(1'b0));

        // R5 layout: make every sum term false, then open single terms
        for (int t = 0; t < NSUM; t++) step(1'b0, 1'b1, 8'(t), 44'h3, 12'h0, 10'h0);
        idle(12'h3C3, 10'h0F0);
        check("R5 all sums low", NT'(sum_out), NT'(0));
        step(1'b0, 1'b1, 8'd59, 44'h0, 12'h3C3, 10'h0F0);
        check("R5 term59 -> out4", NT'(sum_out), NT'(10'h010));
        step(1'b0, 1'b1, 8'd59, 44'h3, 12'h3C3, 10'h0F0);
        step(1'b0, 1'b1, 8'd60, 44'h0, 12'h3C3, 10'h0F0);
        check("R5 term60 -> out5", NT'(sum_out), NT'(10'h020));
        step(1'b0, 1'b1, 8'd60, 44'h3, 12'h3C3, 10'h0F0);
        step(1'b0, 1'b1, 8'd7, 44'h0, 12'h3C3, 10'h0F0);
        check("R5 term7 -> out0", NT'(sum_out), NT'(10'h001));
        step(1'b0, 1'b1, 8'd7, 44'h3, 12'h3C3, 10'h0F0);
        step(1'b0, 1'b1, 8'd8, 44'h0, 12'h3C3, 10'h0F0);
        check("R5 term8 -> out1", NT'(sum_out), NT'(10'h002));
        step(1'b0, 1'b1, 8'd119, 44'h0, 12'h3C3, 10'h0F0);
        check("R5 term119 -> out9", NT'(sum_out), NT'(10'h202));

        // R9 erase with a colliding write
        step(1'b1, 1'b1, 8'd5, 44'h3, 12'h111, 10'h222);
        check("R9 erase all open", pterm_out, {NT{1'b1}});
        check("R9 write ignored", NT'(pterm_out[5]), NT'(1'b1));

        // R10 out-of-range writes
        step(1'b0, 1'b1, 8'd132, 44'h3, 12'h0, 10'h0);
        step(1'b0, 1'b1, 8'd200, 44'h3, 12'h0, 10'h0);
        check("R10 index ignored", pterm_out, {NT{1'b1}});

        // R8 write visible only after the edge (checked in step before the edge)
        step(1'b0, 1'b1, 8'd125, 44'h3, 12'h0, 10'h0);
        check("R8 write landed", NT'(oe_term), NT'(10'h3DF));

        // random traffic
        for (int i = 0; i < 400; i++) begin
            logic [NL-1:0] m;
            m = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}
                & {$urandom, $urandom};
            step(($urandom % 50) == 0, $urandom % 2, 8'($urandom % 140), m,
                 12'($urandom), 10'($urandom));
        end
        idle(12'($urandom), 10'($urandom));

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule